// File: doc/BRIEF.md
# Single-Stage Parallel Comparison Sorter

This block sorts N unsigned words into ascending order in pure combinational logic. It does not use a chain of compare-exchange layers. Instead, it compares every pair of inputs at the same moment. Each input's count of predecessors becomes its rank, and each rank is decoded into a one-hot select. Each output then takes its word from the inputs through a single N-way multiplexer. Ties between equal values are resolved by input position, so the outputs are always a permutation of the inputs.

The inputs arrive as one flat vector, with word k in bits [k*W +: W]. The outputs use the same layout. Output slot 0 holds the smallest value and slot N-1 the largest. N may be set from 2 to 8. A parameter selects how the output multiplexer is built: either an AND-OR tree driven straight from the one-hot select, or an encoder followed by an indexed part-select.

Top module: `psort_top`

## Requirements
- R1: The output words are in non-decreasing unsigned order, with slot 0 holding the smallest value and slot N-1 the largest.
- R2: The output words are a permutation of the input words. This holds when values repeat: each value appears at the output exactly as often as at the input.
- R3: When every input carries the same value, every output carries that value.
- R4: With N=2, output slot 0 equals in0 and slot 1 equals in1 when in0 < in1; otherwise slot 0 equals in1 and slot 1 equals in0.
- R5: The comparison is unsigned, so a word with its top bit set sorts above every word with that bit clear.
- R6: The block holds no state. Outputs follow any input change with no clock edge in between.
- R7: The AND-OR multiplexer variant (MUX_STYLE = MUX_ANDOR) and the encoded-index variant (MUX_STYLE = MUX_INDEX) produce identical outputs for the same inputs.
- R8: Every input receives a unique rank from 0 to N-1. Each output slot selects exactly one input, and each input is selected by exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_words | input | N*W | Unsorted words; word k occupies bits [k*W +: W] |
| out_words | output | N*W | Sorted words; slot 0 holds the smallest value |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the input and output ports. The bench changes the inputs on the falling edge of its pacing clock. It samples all outputs 1 ns later, well before the next rising edge, so each sample sees values settled from that stimulus alone. Consecutive vectors are applied with no idle cycle between them, which exercises the R6 requirement that the block keeps no state.

// File: rtl/psort_pkg.sv
package psort_pkg;

   typedef enum logic {
      MUX_ANDOR = 1'b0,
      MUX_INDEX = 1'b1
   } psort_mux_e;

   function automatic int pair_count(input int n);
      return (n * (n - 1)) / 2;
   endfunction

   function automatic int rank_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/psort_rank.sv
module psort_rank #(
   parameter int N  = 4,
   parameter int W  = 64,
   parameter int RW = 2
) (
   input  logic [N*W-1:0]  in_words,
   output logic [N*RW-1:0] ranks
);
   localparam int PAIRS = psort_pkg::pair_count(N);

   // ahead[i*N+j] = 1 when input j must be placed before input i
   logic [N*N-1:0] ahead;

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (j > i) begin : g_cmp
            logic j_less;
            assign j_less       = in_words[j*W +: W] < in_words[i*W +: W];
            assign ahead[i*N+j] = j_less;
            assign ahead[j*N+i] = ~j_less;
         end else if (j == i) begin : g_diag
            assign ahead[i*N+j] = 1'b0;
         end
      end
   end

   if (PAIRS != (N * (N - 1)) / 2) begin : g_bad_pairs
      $error("psort_rank: comparator count mismatch");
   end

   for (genvar i = 0; i < N; i++) begin : g_cnt
      always_comb begin
         logic [RW-1:0] acc;
         acc = '0;
         for (int j = 0; j < N; j++) begin
            acc = acc + RW'(ahead[i*N+j]);
         end
         ranks[i*RW +: RW] = acc;
      end
   end

   always_comb begin
      if (!$isunknown(ranks)) begin
         for (int i = 0; i < N; i++) begin
            AST_RANK_RANGE: assert (int'(ranks[i*RW +: RW]) < N)
               else $error("rank out of range"); // R8
         end
      end
   end

endmodule

// File: rtl/psort_decode.sv
module psort_decode #(
   parameter int N  = 4,
   parameter int RW = 2
) (
   input  logic [N*RW-1:0] ranks,
   output logic [N*N-1:0]  sel
);
   // sel[k*N+i] = 1 when output slot k takes input i
   for (genvar k = 0; k < N; k++) begin : g_slot
      for (genvar i = 0; i < N; i++) begin : g_src
         assign sel[k*N+i] = (ranks[i*RW +: RW] == RW'(k));
      end
   end

   always_comb begin
      if (!$isunknown(ranks)) begin
         for (int k = 0; k < N; k++) begin
            AST_SLOT_ONEHOT: assert ($countones(sel[k*N +: N]) == 1)
               else $error("slot select not one-hot"); // R8
         end
         for (int i = 0; i < N; i++) begin
            logic [N-1:0] col;
            for (int k = 0; k < N; k++) col[k] = sel[k*N+i];
            AST_SOURCE_ONCE: assert ($countones(col) == 1)
               else $error("input selected not exactly once"); // R2
         end
      end
   end

endmodule

// File: rtl/psort_mux.sv
module psort_mux #(
   parameter int                     N     = 4,
   parameter int                     W     = 64,
   parameter psort_pkg::psort_mux_e  STYLE = psort_pkg::MUX_ANDOR
) (
   input  logic [N*W-1:0] in_words,
   input  logic [N*N-1:0] sel,
   output logic [N*W-1:0] out_words
);
   localparam int IW = psort_pkg::rank_width(N);

   for (genvar k = 0; k < N; k++) begin : g_out
      if (STYLE == psort_pkg::MUX_ANDOR) begin : g_andor
         always_comb begin
            logic [W-1:0] acc;
            acc = '0;
            for (int i = 0; i < N; i++) begin
               acc = acc | ({W{sel[k*N+i]}} & in_words[i*W +: W]);
            end
            out_words[k*W +: W] = acc;
         end
      end else begin : g_index
         logic [IW-1:0] idx;
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (sel[k*N+i]) idx = idx | IW'(i);
            end
         end
         assign out_words[k*W +: W] = in_words[int'(idx)*W +: W];
      end
   end

endmodule

// File: rtl/psort_top.sv
module psort_top #(
   parameter int                    N         = 4,
   parameter int                    W         = 64,
   parameter psort_pkg::psort_mux_e MUX_STYLE = psort_pkg::MUX_ANDOR
) (
   input  logic [N*W-1:0] in_words,
   output logic [N*W-1:0] out_words
);
   localparam int RW = psort_pkg::rank_width(N);

   if (N < 2 || N > 8) begin : g_bad_n
      $error("psort_top: N must lie in 2..8");
   end
   if (W < 1) begin : g_bad_w
      $error("psort_top: W must be positive");
   end

   logic [N*RW-1:0] ranks;
   logic [N*N-1:0]  sel;

   psort_rank #(.N(N), .W(W), .RW(RW)) u_rank (
      .in_words (in_words),
      .ranks    (ranks)
   );

   psort_decode #(.N(N), .RW(RW)) u_decode (
      .ranks (ranks),
      .sel   (sel)
   );

   psort_mux #(.N(N), .W(W), .STYLE(MUX_STYLE)) u_mux (
      .in_words  (in_words),
      .sel       (sel),
      .out_words (out_words)
   );

   always_comb begin
      if (!$isunknown(out_words)) begin
         for (int k = 0; k + 1 < N; k++) begin
            AST_ASCENDING: assert (out_words[k*W +: W] <= out_words[(k+1)*W +: W])
               else $error("outputs out of order"); // R1
         end
      end
   end

   if (N == 2) begin : g_pair_chk
      always_comb begin
         if (!$isunknown(out_words) && !$isunknown(in_words)) begin
            AST_TWO_SORTER: assert (out_words == ((in_words[W-1:0] < in_words[2*W-1:W])
                                                  ? in_words
                                                  : {in_words[W-1:0], in_words[2*W-1:W]}))
               else $error("two-input ordering wrong"); // R4
         end
      end
   end

endmodule

// File: tb/tb_psort_top.sv
module tb_psort_top;
   localparam int N  = 4;
   localparam int W  = 64;
   localparam int W2 = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int cyc = 0;

   logic [N*W-1:0]  a_in, a_out, b_out;
   logic [2*W2-1:0] p_in, p_out;

   psort_top #(.N(N), .W(W), .MUX_STYLE(psort_pkg::MUX_ANDOR)) dut (
      .in_words(a_in), .out_words(a_out));
   psort_top #(.N(N), .W(W), .MUX_STYLE(psort_pkg::MUX_INDEX)) dut_idx (
      .in_words(a_in), .out_words(b_out));
   psort_top #(.N(2), .W(W2), .MUX_STYLE(psort_pkg::MUX_ANDOR)) dut_pair (
      .in_words(p_in), .out_words(p_out));

   function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
      logic [W-1:0] a [N];
      logic [W-1:0] t;
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
      for (int i = 1; i < N; i++) begin
         for (int j = i; j > 0; j--) begin
            if (a[j] < a[j-1]) begin
               t = a[j]; a[j] = a[j-1]; a[j-1] = t;
            end
         end
      end
      for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
      return r;
   endfunction

   function automatic bit is_ascending(input logic [N*W-1:0] v);
      for (int k = 0; k + 1 < N; k++)
         if (v[k*W +: W] > v[(k+1)*W +: W]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply at falling edge, sample 1 ns later (no register in the path)
   task automatic apply_main(input logic [N*W-1:0] v, input string tag);
      logic [N*W-1:0] e;
      @(negedge clk);
      a_in = v;
      #1;
      e = ref_sort(v);
      check(is_ascending(a_out), {tag, " R1 order"}, a_out, e);
      check(a_out === e, {tag, " R2 permutation"}, a_out, e);
      check(b_out === a_out, {tag, " R7 mux variants"}, b_out, a_out);
   endtask

   task automatic apply_pair(input logic [W2-1:0] x0, input logic [W2-1:0] x1);
      logic [2*W2-1:0] e;
      @(negedge clk);
      p_in = {x1, x0};
      #1;
      e = (x0 < x1) ? {x1, x0} : {x0, x1};
      check(p_out === e, "R4 two-sorter", N*W'(p_out), N*W'(e));
   endtask

   function automatic logic [W-1:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!done && cyc > 100000) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N*W-1:0] v;
      logic [W-1:0]   c;
      void'($urandom(32'h5EED_0042));
      a_in = '0;
      p_in = '0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      #1;
      check(a_out === '0, "R6 zero input", a_out, '0);

      // R3: all equal
      c = 64'hDEAD_BEEF_0123_4567;
      apply_main({N{c}}, "R3 all-equal");
      check(a_out === {N{c}}, "R3 every slot equals value", a_out, {N{c}});

      // R5: top bit set sorts above
      apply_main({64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
                  64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}, "R5 unsigned");
      check(a_out[(N-1)*W +: W] === 64'hFFFF_FFFF_FFFF_FFFF, "R5 largest",
            a_out, {64'hFFFF_FFFF_FFFF_FFFF, 192'd0});
      check(a_out[(N-2)*W +: W] === 64'h8000_0000_0000_0000, "R5 second",
            a_out, {64'h0, 64'h8000_0000_0000_0000, 128'd0});

      // directed orders: descending, ascending, duplicate pairs
      apply_main({64'd1, 64'd2, 64'd3, 64'd4}, "R1 descending");
      apply_main({64'd4, 64'd3, 64'd2, 64'd1}, "R1 ascending");
      apply_main({64'd7, 64'd2, 64'd7, 64'd2}, "R2 dup pairs");
      apply_main({64'd0, 64'd9, 64'd9, 64'd9}, "R2 triple dup");

      // R6: back-to-back vectors, each settled without clocking state
      for (int n = 0; n < 300; n++) begin
         for (int k = 0; k < N; k++) v[k*W +: W] = rnd64();
         apply_main(v, "R6 random");
      end
      // heavy duplicates from a tiny value pool
      for (int n = 0; n < 300; n++) begin
         for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom_range(0, 2));
         apply_main(v, "R2 random dups");
      end

      // R4: two-input block
      apply_pair(8'd3, 8'd9);
      apply_pair(8'd9, 8'd3);
      apply_pair(8'd5, 8'd5);
      apply_pair(8'h80, 8'h7F);
      for (int n = 0; n < 100; n++) apply_pair(W2'($urandom), W2'($urandom));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule